// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave

This block is a synthesizable model of a 256-byte serial memory that sits on a two-wire bus as a slave. It watches a sampled clock line and a data line. It answers through a single pull-low enable, and the surrounding logic turns that enable into an open-drain driver. It recognises bus start and stop conditions and compares the upper seven bits of each control byte with its own device address. It acknowledges bytes by holding the data line low during the ninth clock pulse.

Writes first set a word address, then collect data bytes into an eight-entry page buffer. Within a page, only the low three address bits advance. When a stop ends a write that carried data, a timed internal cycle copies the buffer into the storage array. For the length of that cycle the device ignores its address, so a master can poll it until it answers again. Reads return bytes from an address pointer that advances across the whole array. A write-protect input makes the block keep every stored byte unchanged, while reads still work.

Top module: `ser_eeprom_slave`

## Requirements
- R1: A falling data line while the clock is high is a start, and a rising data line while the clock is high is a stop. The pull-low enable changes only while the sampled clock is low, and it is released after reset.
- R2: A control byte is acknowledged (data held low during the ninth pulse) only when its bits 7..1 equal DEV_ADDR (default 7'h50) and no internal write cycle runs. Bit 0 selects read (1) or write (0). A control byte that is not acknowledged ends the transfer.
- R3: In a write, the byte after the control byte is the word address. Each data byte is acknowledged and stored at the pointer, after which only pointer bits 2..0 increment and bits 7..3 stay fixed. Bytes outside the addressed page are unchanged.
- R4: When more than eight data bytes arrive before the stop, the in-page address wraps and later bytes replace earlier ones at the same location.
- R5: A stop that follows a write with at least one complete data byte starts an internal cycle of WCYC clocks (default 600). A control byte sent during the cycle gets no acknowledge. After the cycle ends, control bytes are acknowledged again.
- R6: A write carrying only a word address, followed by a repeated start and a read control byte, returns the byte at that word address and stores nothing.
- R7: In a read, the pointer advances after every byte sent and wraps from 255 to 0. The master acknowledges to receive another byte. A non-acknowledge ends the read.
- R8: After reset, every location reads 8'hFF and the pointer is 0. A current-address read returns the byte one past the last one accessed.
- R9: While write-protect is high, address and data bytes are still acknowledged, but the stop starts no internal cycle and storage stays unchanged. Reads work normally.
- R10: A start or stop that arrives after two or more bits of a byte aborts the transfer and discards buffered data. A stop after a write that carried only a word address starts no internal cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the bus lines |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Sampled level of the bus clock line |
| sda_i | input | 1 | Sampled level of the bus data line |
| wp_i | input | 1 | Write-protect; high blocks all programming |
| sda_pull_o | output | 1 | High pulls the data line low |

## Verification
The assertions assume that the data line moves only while the clock is low, except during start and stop conditions. They also assume that each bus phase lasts several system clocks, so that the two-register edge detection catches every transition. They further assume that the master never issues a start or stop while the slave is holding the line low, and that write-protect is steady around a stop. The bench models the bus as a wired AND of the master's drive and the slave's pull. It moves the clock and data lines on separate system-clock steps eight clocks apart. It changes write-protect only while the bus is idle.

// File: rtl/ee_pkg.sv
package ee_pkg;
    localparam int EE_BYTE_W = 8;

    typedef enum logic [3:0] {
        S_IDLE,
        S_CTRL,
        S_CACK,
        S_WADDR,
        S_AACK,
        S_WDATA,
        S_DACK,
        S_RDATA,
        S_RACK
    } ee_state_e;
endpackage

// File: rtl/ee_line_sync.sv
module ee_line_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_hi,
    output logic sda_hi,
    output logic scl_rise,
    output logic scl_fall,
    output logic bus_start,
    output logic bus_stop
);
    typedef struct packed {
        logic scl_now;
        logic scl_old;
        logic sda_now;
        logic sda_old;
    } line_t;

    line_t ln_d, ln_q;

    always_comb begin
        ln_d         = ln_q;
        ln_d.scl_old = ln_q.scl_now;
        ln_d.sda_old = ln_q.sda_now;
        ln_d.scl_now = scl_i;
        ln_d.sda_now = sda_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ln_q <= '1;
        else        ln_q <= ln_d;
    end

    assign scl_hi    = ln_q.scl_now;
    assign sda_hi    = ln_q.sda_now;
    assign scl_rise  = ln_q.scl_now & ~ln_q.scl_old;
    assign scl_fall  = ~ln_q.scl_now & ln_q.scl_old;
    assign bus_start = ln_q.scl_now & ln_q.scl_old & ln_q.sda_old & ~ln_q.sda_now;
    assign bus_stop  = ln_q.scl_now & ln_q.scl_old & ~ln_q.sda_old & ln_q.sda_now;
endmodule

// File: rtl/ee_page_buf.sv
module ee_page_buf #(
    parameter int PAGE_W = 3,
    parameter int DATA_W = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          clr_i,
    input  logic                          wr_i,
    input  logic [PAGE_W-1:0]             idx_i,
    input  logic [DATA_W-1:0]             data_i,
    output logic [(1<<PAGE_W)-1:0]        vld_o,
    output logic [(1<<PAGE_W)-1:0][DATA_W-1:0] data_o
);
    localparam int PAGE = 1 << PAGE_W;

    for (genvar g = 0; g < PAGE; g++) begin : g_slot
        logic              vld_d, vld_q;
        logic [DATA_W-1:0] dat_d, dat_q;

        always_comb begin
            vld_d = vld_q;
            dat_d = dat_q;
            if (clr_i) begin
                vld_d = 1'b0;
            end else if (wr_i && idx_i == PAGE_W'(g)) begin
                vld_d = 1'b1;
                dat_d = data_i;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                vld_q <= 1'b0;
                dat_q <= '0;
            end else begin
                vld_q <= vld_d;
                dat_q <= dat_d;
            end
        end

        assign vld_o[g]  = vld_q;
        assign data_o[g] = dat_q;
    end
endmodule

// File: rtl/ee_wcycle.sv
module ee_wcycle #(
    parameter int ADDR_W = 8,
    parameter int PAGE_W = 3,
    parameter int DATA_W = 8,
    parameter int WCYC   = 600
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               go_i,
    input  logic [ADDR_W-PAGE_W-1:0]           base_i,
    input  logic [(1<<PAGE_W)-1:0]             vld_i,
    input  logic [(1<<PAGE_W)-1:0][DATA_W-1:0] data_i,
    output logic                               busy_o,
    output logic                               done_o,
    output logic                               we_o,
    output logic [ADDR_W-1:0]                  waddr_o,
    output logic [DATA_W-1:0]                  wdata_o
);
    localparam int PAGE = 1 << PAGE_W;
    localparam int CW   = (WCYC > PAGE) ? $clog2(WCYC + 1) : PAGE_W + 1;
    localparam logic [CW-1:0] LAST   = CW'(WCYC - 1);
    localparam logic [CW-1:0] PAGE_C = CW'(PAGE);

    typedef struct packed {
        logic                     busy;
        logic [CW-1:0]            cnt;
        logic [ADDR_W-PAGE_W-1:0] base;
    } wc_t;

    wc_t wc_d, wc_q;
    logic [PAGE_W-1:0] slot;

    assign slot = wc_q.cnt[PAGE_W-1:0];

    always_comb begin
        wc_d   = wc_q;
        done_o = 1'b0;
        if (!wc_q.busy) begin
            if (go_i) begin
                wc_d.busy = 1'b1;
                wc_d.cnt  = '0;
                wc_d.base = base_i;
            end
        end else if (wc_q.cnt == LAST) begin
            wc_d.busy = 1'b0;
            done_o    = 1'b1;
        end else begin
            wc_d.cnt = wc_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) wc_q <= '0;
        else        wc_q <= wc_d;
    end

    assign busy_o  = wc_q.busy;
    assign we_o    = wc_q.busy && (wc_q.cnt < PAGE_C) && vld_i[slot];
    assign waddr_o = {wc_q.base, slot};
    assign wdata_o = data_i[slot];

    a_r5_cycle_length: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wc_q.busy) |-> $past(wc_q.cnt) == LAST);
    a_r5_write_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
        we_o |-> ($past(wc_q.busy) || $past(go_i)));
endmodule

// File: rtl/ee_mem_array.sv
module ee_mem_array #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] waddr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [ADDR_W-1:0] raddr_i,
    output logic [DATA_W-1:0] rdata_o
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem_d [DEPTH];
    logic [DATA_W-1:0] mem_q [DEPTH];

    always_comb begin
        mem_d = mem_q;
        if (we_i) mem_d[waddr_i] = wdata_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '1;
        end else begin
            mem_q <= mem_d;
        end
    end

    assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/ser_eeprom_slave.sv
module ser_eeprom_slave #(
    parameter int         ADDR_W   = 8,
    parameter int         PAGE_W   = 3,
    parameter logic [6:0] DEV_ADDR = 7'h50,
    parameter int         WCYC     = 600
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    input  logic wp_i,
    output logic sda_pull_o
);
    import ee_pkg::*;

    localparam int BW   = EE_BYTE_W;
    localparam int PAGE = 1 << PAGE_W;

    typedef struct packed {
        ee_state_e         state;
        logic [3:0]        cnt;
        logic [BW-1:0]     sh;
        logic [ADDR_W-1:0] ptr;
        logic              rd;
        logic              ack;
        logic              more;
        logic              pull;
    } ctl_t;

    ctl_t r_d, r_q;

    logic scl_hi, sda_hi, scl_rise, scl_fall, bus_start, bus_stop;
    logic buf_wr, buf_clr, go, busy, done, match, rx_done, boundary;
    logic [PAGE-1:0]         buf_vld;
    logic [PAGE-1:0][BW-1:0] buf_data;
    logic                    mem_we;
    logic [ADDR_W-1:0]       mem_waddr;
    logic [BW-1:0]           mem_wdata, mem_rdata;

    ee_line_sync u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_hi(scl_hi), .sda_hi(sda_hi), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .bus_start(bus_start), .bus_stop(bus_stop)
    );

    ee_page_buf #(.PAGE_W(PAGE_W), .DATA_W(BW)) u_buf (
        .clk(clk), .rst_n(rst_n), .clr_i(buf_clr | done), .wr_i(buf_wr),
        .idx_i(r_q.ptr[PAGE_W-1:0]), .data_i(r_q.sh),
        .vld_o(buf_vld), .data_o(buf_data)
    );

    ee_wcycle #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .DATA_W(BW), .WCYC(WCYC)) u_wcyc (
        .clk(clk), .rst_n(rst_n), .go_i(go), .base_i(r_q.ptr[ADDR_W-1:PAGE_W]),
        .vld_i(buf_vld), .data_i(buf_data), .busy_o(busy), .done_o(done),
        .we_o(mem_we), .waddr_o(mem_waddr), .wdata_o(mem_wdata)
    );

    ee_mem_array #(.ADDR_W(ADDR_W), .DATA_W(BW)) u_mem (
        .clk(clk), .rst_n(rst_n), .we_i(mem_we), .waddr_i(mem_waddr),
        .wdata_i(mem_wdata), .raddr_i(r_q.ptr), .rdata_o(mem_rdata)
    );

    assign match    = (r_q.sh[7:1] == DEV_ADDR) && !busy;
    assign rx_done  = scl_fall && (r_q.cnt == 4'd8);
    assign boundary = (r_q.cnt <= 4'd1);

    always_comb begin
        r_d     = r_q;
        buf_wr  = 1'b0;
        buf_clr = 1'b0;
        go      = 1'b0;
        if (bus_start) begin
            r_d.state = S_CTRL;
            r_d.cnt   = '0;
            r_d.pull  = 1'b0;
            buf_clr   = !busy;
        end else if (bus_stop) begin
            go        = (r_q.state == S_WDATA) && boundary && (|buf_vld) && !wp_i;
            buf_clr   = !busy && !go;
            r_d.state = S_IDLE;
            r_d.pull  = 1'b0;
        end else begin
            unique case (r_q.state)
                S_CTRL, S_WADDR, S_WDATA: begin
                    if (scl_rise && r_q.cnt < 4'd8) begin
                        r_d.sh  = {r_q.sh[BW-2:0], sda_hi};
                        r_d.cnt = r_q.cnt + 4'd1;
                    end else if (rx_done) begin
                        r_d.cnt  = '0;
                        r_d.pull = 1'b1;
                        if (r_q.state == S_CTRL) begin
                            r_d.ack   = match;
                            r_d.pull  = match;
                            r_d.rd    = r_q.sh[0];
                            r_d.state = S_CACK;
                        end else if (r_q.state == S_WADDR) begin
                            r_d.ptr   = r_q.sh[ADDR_W-1:0];
                            r_d.state = S_AACK;
                        end else begin
                            buf_wr = 1'b1;
                            r_d.ptr[PAGE_W-1:0] = r_q.ptr[PAGE_W-1:0] + 1'b1;
                            r_d.state = S_DACK;
                        end
                    end
                end
                S_CACK: begin
                    if (scl_fall) begin
                        r_d.pull = 1'b0;
                        if (!r_q.ack) begin
                            r_d.state = S_IDLE;
                        end else if (r_q.rd) begin
                            r_d.sh    = mem_rdata;
                            r_d.ptr   = r_q.ptr + 1'b1;
                            r_d.pull  = !mem_rdata[BW-1];
                            r_d.cnt   = '0;
                            r_d.state = S_RDATA;
                        end else begin
                            r_d.state = S_WADDR;
                        end
                    end
                end
                S_AACK, S_DACK: begin
                    if (scl_fall) begin
                        r_d.pull  = 1'b0;
                        r_d.state = S_WDATA;
                    end
                end
                S_RDATA: begin
                    if (scl_rise) begin
                        r_d.cnt = r_q.cnt + 4'd1;
                    end else if (scl_fall) begin
                        if (r_q.cnt == 4'd8) begin
                            r_d.pull  = 1'b0;
                            r_d.state = S_RACK;
                        end else begin
                            r_d.sh   = {r_q.sh[BW-2:0], 1'b1};
                            r_d.pull = !r_q.sh[BW-2];
                        end
                    end
                end
                S_RACK: begin
                    if (scl_rise) begin
                        r_d.more = !sda_hi;
                    end else if (scl_fall) begin
                        if (r_q.more) begin
                            r_d.sh    = mem_rdata;
                            r_d.ptr   = r_q.ptr + 1'b1;
                            r_d.pull  = !mem_rdata[BW-1];
                            r_d.cnt   = '0;
                            r_d.state = S_RDATA;
                        end else begin
                            r_d.state = S_IDLE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.state <= S_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign sda_pull_o = r_q.pull;

    // R1: the pull enable moves only on a low sampled clock
    a_r1_pull_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.pull != $past(r_q.pull)) |-> !$past(scl_hi));
    // R2: the control acknowledge is never given during an internal cycle
    a_r2_no_ack_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == S_CACK && r_q.pull) |-> !busy);
    // R3: page bits of the pointer hold while data bytes stream in
    a_r3_page_bits_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        ((r_q.state == S_WDATA || r_q.state == S_DACK) &&
         ($past(r_q.state) == S_WDATA || $past(r_q.state) == S_DACK))
        |-> $stable(r_q.ptr[ADDR_W-1:PAGE_W]));
    // R9: an internal cycle never begins under write-protect
    a_r9_protect_no_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !$past(wp_i));
    // R10: an aborted or address-only write never begins a cycle
    a_r10_cycle_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(r_q.state) == S_WDATA);
endmodule

// File: tb/ser_eeprom_slave_tb.sv
module ser_eeprom_slave_tb;
    localparam int H    = 8;
    localparam int WCYC = 600;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic m_sda = 1'b1;
    logic wp = 1'b0;
    logic sda_pull;
    logic sda_line;

    int total = 0;
    int bad = 0;
    logic [7:0] exp_mem [256];
    logic [7:0] rbuf [16];

    always #2 clk = ~clk;

    assign sda_line = m_sda & ~sda_pull;

    ser_eeprom_slave #(.WCYC(WCYC)) u_dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
        .wp_i(wp), .sda_pull_o(sda_pull)
    );

    localparam logic [15:0] VEC [5] = '{
        {8'h00, 8'h3C}, {8'h01, 8'hC3}, {8'h07, 8'hA5}, {8'h80, 8'h11}, {8'hFF, 8'h5A}
    };

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic hw(input int n = H);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; hw(); scl = 1'b1; hw(); m_sda = 1'b0; hw(); scl = 1'b0; hw();
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; hw(); scl = 1'b1; hw(); m_sda = 1'b1; hw();
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            m_sda = b[i]; hw(); scl = 1'b1; hw(); scl = 1'b0;
        end
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked);
        send_bits(b, 8);
        m_sda = 1'b1; hw(); scl = 1'b1; hw(H/2);
        acked = !sda_line;
        hw(H/2); scl = 1'b0;
    endtask

    task automatic recv_byte(input logic mack, output logic [7:0] b);
        m_sda = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            hw(); scl = 1'b1; hw(H/2); b[i] = sda_line; hw(H/2); scl = 1'b0;
        end
        m_sda = !mack; hw(); scl = 1'b1; hw(); scl = 1'b0; m_sda = 1'b1;
    endtask

    task automatic rand_read(input logic [7:0] a, input int n, output logic ok);
        logic k1, k2, k3;
        logic [7:0] b;
        bus_start(); send_byte(8'hA0, k1); send_byte(a, k2);
        bus_start(); send_byte(8'hA1, k3);
        for (int i = 0; i < n; i++) begin
            recv_byte(i != n - 1, b);
            rbuf[i] = b;
        end
        bus_stop();
        ok = k1 & k2 & k3;
    endtask

    initial begin
        logic k, ka, kall;
        logic [7:0] b;
        for (int i = 0; i < 256; i++) exp_mem[i] = 8'hFF;
        hw(5);
        // R1: released bus after reset
        chk(sda_pull == 1'b0, "R1 reset pull", 32'(sda_pull), 0);
        rst_n = 1'b1;
        hw(5);

        // R8: current-address read right after reset hits location 0
        bus_start(); send_byte(8'hA1, k); recv_byte(1'b0, b); bus_stop();
        chk(k, "R2 read ctrl ack", 32'(k), 1);
        chk(b == exp_mem[0], "R8 reset read", 32'(b), 32'(exp_mem[0]));

        // R3 R5 R6: vector table of byte writes, polls and random reads
        for (int v = 0; v < 5; v++) begin
            bus_start(); send_byte(8'hA0, k); kall = k;
            send_byte(VEC[v][15:8], k); kall &= k;
            send_byte(VEC[v][7:0], k); kall &= k;
            bus_stop();
            exp_mem[VEC[v][15:8]] = VEC[v][7:0];
            chk(kall, "R3 write acks", 32'(kall), 1);
            bus_start(); send_byte(8'hA0, k); bus_stop();
            chk(!k, "R5 busy poll nack", 32'(k), 0);
            hw(WCYC + 40);
            rand_read(VEC[v][15:8], 1, ka);
            chk(ka, "R5 ack after cycle", 32'(ka), 1);
            chk(rbuf[0] == VEC[v][7:0], "R6 random read", 32'(rbuf[0]), 32'(VEC[v][7:0]));
        end

        // R4: ten bytes into page at 0x13 wrap inside 0x10..0x17
        bus_start(); send_byte(8'hA0, k); send_byte(8'h13, k);
        for (int j = 0; j < 10; j++) begin
            send_byte(8'h60 + 8'(j), k);
            exp_mem[8'h10 | ((3 + j) & 7)] = 8'h60 + 8'(j);
        end
        bus_stop();
        hw(WCYC + 40);
        rand_read(8'h10, 9, ka);
        for (int j = 0; j < 8; j++)
            chk(rbuf[j] == exp_mem[8'h10 + j], "R4 page wrap", 32'(rbuf[j]), 32'(exp_mem[8'h10 + j]));
        // R3: byte outside the page untouched
        chk(rbuf[8] == exp_mem[8'h18], "R3 outside page", 32'(rbuf[8]), 32'(exp_mem[8'h18]));

        // R7: sequential read wraps from 0xFF to 0x00
        rand_read(8'hFE, 3, ka);
        chk(rbuf[0] == exp_mem[8'hFE], "R7 seq 0xFE", 32'(rbuf[0]), 32'(exp_mem[8'hFE]));
        chk(rbuf[1] == exp_mem[8'hFF], "R7 seq 0xFF", 32'(rbuf[1]), 32'(exp_mem[8'hFF]));
        chk(rbuf[2] == exp_mem[8'h00], "R7 seq wrap 0x00", 32'(rbuf[2]), 32'(exp_mem[8'h00]));

        // R8: current-address read continues at 0x01
        bus_start(); send_byte(8'hA1, k); recv_byte(1'b0, b); bus_stop();
        chk(b == exp_mem[8'h01], "R8 current read", 32'(b), 32'(exp_mem[8'h01]));

        // R2: wrong device address gets no acknowledge
        bus_start(); send_byte(8'hA2, k); bus_stop();
        chk(!k, "R2 address mismatch nack", 32'(k), 0);

        // R9: write-protect acks but stores nothing and stays idle
        wp = 1'b1; hw();
        bus_start(); send_byte(8'hA0, k); kall = k;
        send_byte(8'h40, k); kall &= k; send_byte(8'hE7, k); kall &= k;
        bus_stop();
        chk(kall, "R9 protected acks", 32'(kall), 1);
        bus_start(); send_byte(8'hA0, k); bus_stop();
        chk(k, "R9 no busy under protect", 32'(k), 1);
        rand_read(8'h40, 1, ka);
        chk(ka && rbuf[0] == exp_mem[8'h40], "R9 read under protect", 32'(rbuf[0]), 32'(exp_mem[8'h40]));
        hw(); wp = 1'b0; hw();

        // R10: stop after four data bits aborts the write
        bus_start(); send_byte(8'hA0, k); send_byte(8'h20, k);
        send_bits(8'h99, 4); bus_stop();
        bus_start(); send_byte(8'hA0, k); bus_stop();
        chk(k, "R10 abort starts no cycle", 32'(k), 1);
        hw(WCYC + 40);
        rand_read(8'h20, 1, ka);
        chk(rbuf[0] == exp_mem[8'h20], "R10 abort leaves data", 32'(rbuf[0]), 32'(exp_mem[8'h20]));

        // R10: address-only write then stop starts no cycle
        bus_start(); send_byte(8'hA0, k); send_byte(8'h30, k); bus_stop();
        bus_start(); send_byte(8'hA0, k); bus_stop();
        chk(k, "R10 address-only no cycle", 32'(k), 1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog all act=hung exp=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule